// File: doc/BRIEF.md
# Mode-Selectable Synchronous FIFO

A single-clock FIFO whose read timing is chosen once per reset. The level on a timing-select input at the first rising clock edge after reset release decides the mode. A low level selects first-word-fall-through (FWFT): the head word is presented on the read data output without a read request, and a read enable moves the next word up. A high level selects standard mode: a read enable that is accepted fetches a word, which appears on the output after that clock edge.

The two status outputs change meaning with the mode. In FWFT mode they are output-ready (a valid, unconsumed word is on the output) and input-ready (the storage array has a free location). In standard mode they are the active-high empty and full flags. Writes while the storage is full and reads while nothing is available are dropped. Depth and data width are parameters.

Top module: `modesel_fifo`

## Requirements
- R1: The timing mode is taken from `mode_sel_i` at the first rising clock edge after `rst_ni` goes high: 0 selects FWFT and 1 selects standard. During reset and during the cycle before that edge, the flags follow the mode that the pin currently selects.
- R2: After that edge the mode stays fixed until the next reset. Later changes on `mode_sel_i` do not change the flag semantics or the read behaviour.
- R3: In FWFT mode, a word written while the FIFO is empty is driven on `rd_data_o` with `out_flag_o` high after the clock edge that follows the write edge. No read enable is needed.
- R4: In FWFT mode, `out_flag_o` (output-ready) is high exactly when `rd_data_o` holds a valid word that has not been consumed. While no read is issued, that word and the flag stay unchanged.
- R5: In FWFT mode, `in_flag_o` (input-ready) is high exactly when fewer than DEPTH words are in the storage array. The output register holds one more word, so the total capacity is DEPTH+1.
- R6: In FWFT mode, a read with output-ready high consumes the presented word. At the same edge the next stored word moves onto the output. If no word is stored, output-ready falls at that edge. A write at the same edge into the emptied FIFO raises output-ready one cycle later.
- R7: In standard mode, `out_flag_o` is the empty flag (high when no word is stored) and `in_flag_o` is the full flag (high when DEPTH words are stored).
- R8: In standard mode, a read accepted at an edge places the oldest word on `rd_data_o` at that edge. Otherwise `rd_data_o` holds its value.
- R9: A write while the storage is full, a standard read while empty, or an FWFT read while output-ready is low is ignored. It stores nothing, consumes nothing and leaves `rd_data_o` unchanged.
- R10: While `rst_ni` is low, the FIFO is emptied and `rd_data_o` is 0. In FWFT mode output-ready is low and input-ready is high. In standard mode empty is high and full is low.
- R11: Words leave in the order they were written, in both modes and under any mix of reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_sel_i | input | 1 | Timing select, sampled once after reset (0 FWFT, 1 standard) |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Read data |
| out_flag_o | output | 1 | FWFT: output-ready; standard: empty |
| in_flag_o | output | 1 | FWFT: input-ready; standard: full |

## Verification
In standard mode, a write edge updates the flags at that same edge, and a read edge updates the data at that same edge. In FWFT mode a word needs one extra edge to reach the output register, so output-ready rises one cycle after the write edge into an empty FIFO. The bench drives inputs on the falling edge and advances a queue-based model by one accepted edge. It compares data and both flags at the next falling edge, so every result is checked in the cycle it becomes due. Mode changes on the select pin are applied mid-run to show that the flag polarity does not follow them.

// File: rtl/modesel_fifo_pkg.sv
package modesel_fifo_pkg;
  typedef enum logic {
    MODE_FWFT = 1'b0,
    MODE_STD  = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_mode_latch.sv
module fifo_mode_latch
  import modesel_fifo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_sel_i,
  output logic fwft_o,
  output logic locked_o
);
  rd_mode_e mode_q;
  logic     locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_FWFT;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      mode_q   <= rd_mode_e'(mode_sel_i);
      locked_q <= 1'b1;
    end
  end

  // transparent to the pin until the first edge after reset
  assign fwft_o   = locked_q ? (mode_q == MODE_FWFT) : (rd_mode_e'(mode_sel_i) == MODE_FWFT);
  assign locked_o = locked_q;
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fifo_ptrs.sv
module fifo_ptrs #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  CAP  = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= bump(wptr_q);
      if (pop_i)  rptr_q <= bump(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign waddr_o = wptr_q;
  assign raddr_o = rptr_q;
  assign cnt_o   = cnt_q;
  assign full_o  = (cnt_q == CAP);
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/fifo_rd_stage.sv
module fifo_rd_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwft_i,
  input  logic              rd_en_i,
  input  logic              mem_empty_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              pop_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  // FWFT: refill whenever the output slot is free or being consumed
  assign take  = fwft_i ? (!valid_q || rd_en_i) : rd_en_i;
  assign pop_o = take && !mem_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (pop_o) data_q <= mem_rdata_i;
      if (!fwft_i)   valid_q <= 1'b0;
      else if (take) valid_q <= !mem_empty_i;
    end
  end

  assign valid_o   = valid_q;
  assign rd_data_o = data_q;
endmodule

// File: rtl/modesel_fifo.sv
module modesel_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              out_flag_o,
  output logic              in_flag_o
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              fwft_w, locked_w;
  logic              push_w, pop_w, full_w, empty_w, ov_w;
  logic [ADDR_W-1:0] waddr_w, raddr_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [DATA_W-1:0] mem_rdata_w;

  fifo_mode_latch u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_sel_i (mode_sel_i),
    .fwft_o     (fwft_w),
    .locked_o   (locked_w)
  );

  assign push_w = wr_en_i && !full_w;

  fifo_ptrs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_w),
    .pop_i   (pop_w),
    .waddr_o (waddr_w),
    .raddr_o (raddr_w),
    .cnt_o   (cnt_w),
    .full_o  (full_w),
    .empty_o (empty_w)
  );

  fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (push_w),
    .waddr_i (waddr_w),
    .wdata_i (wr_data_i),
    .raddr_i (raddr_w),
    .rdata_o (mem_rdata_w)
  );

  fifo_rd_stage #(.DATA_W(DATA_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fwft_i      (fwft_w),
    .rd_en_i     (rd_en_i),
    .mem_empty_i (empty_w),
    .mem_rdata_i (mem_rdata_w),
    .pop_o       (pop_w),
    .valid_o     (ov_w),
    .rd_data_o   (rd_data_o)
  );

  assign out_flag_o = fwft_w ? ov_w : empty_w;
  assign in_flag_o  = fwft_w ? !full_w : full_w;
endmodule

// File: rtl/modesel_fifo_chk.sv
module modesel_fifo_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              out_flag_o,
  input logic              in_flag_o,
  input logic              fwft_w,
  input logic              locked_w,
  input logic [CNT_W-1:0]  cnt_w,
  input logic              ov_w
);
  p_lock_once_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_w |=> locked_w);

  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_w && $past(locked_w)) |-> (fwft_w == $past(fwft_w)));

  p_fall_through_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft_w && !ov_w && cnt_w != '0) |=> out_flag_o);

  p_hold_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft_w && out_flag_o && !rd_en_i) |=> (out_flag_o && $stable(rd_data_o)));

  p_ready_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft_w && ov_w && rd_en_i && cnt_w == '0) |=> !out_flag_o);

  p_std_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft_w && !rd_en_i) |=> $stable(rd_data_o));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft_w && in_flag_o && !rd_en_i) |=> in_flag_o);

  p_empty_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft_w && out_flag_o && !wr_en_i) |=> (out_flag_o && $stable(rd_data_o)));

  p_reset_state_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cnt_w == '0 && !ov_w));
endmodule

bind modesel_fifo modesel_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .out_flag_o (out_flag_o),
  .in_flag_o  (in_flag_o),
  .fwft_w     (fwft_w),
  .locked_w   (locked_w),
  .cnt_w      (cnt_w),
  .ov_w       (ov_w)
);

// File: tb/modesel_fifo_tb_top.sv
`timescale 1ns/1ps
module modesel_fifo_tb_top;
  localparam int DW    = 16;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          out_flag, in_flag;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R10";

  // reference model
  logic [DW-1:0] q[$];
  bit            m_set, m_fwft, m_ov;
  logic [DW-1:0] m_dout;

  always #2 clk = ~clk;

  modesel_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mode_sel_i (sel),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_en_i    (rd_en),
    .rd_data_o  (rd_data),
    .out_flag_o (out_flag),
    .in_flag_o  (in_flag)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit eff_fwft();
    return m_set ? m_fwft : !sel;
  endfunction

  task automatic compare_all();
    bit f = eff_fwft();
    check(cur_tag, "rd_data", 32'(rd_data), 32'(m_dout));
    if (f) begin
      check(cur_tag, "out_ready", 32'(out_flag), 32'(m_ov));
      check(cur_tag, "in_ready", 32'(in_flag), 32'(q.size() < DEPTH));
    end else begin
      check(cur_tag, "empty", 32'(out_flag), 32'(q.size() == 0));
      check(cur_tag, "full", 32'(in_flag), 32'(q.size() == DEPTH));
    end
  endtask

  task automatic model_edge(input bit wr, input logic [DW-1:0] d, input bit rd);
    bit f = eff_fwft();
    bit wr_ok = wr && (q.size() < DEPTH);
    if (f) begin
      if (!m_ov || rd) begin
        if (q.size() > 0) begin
          m_dout = q.pop_front();
          m_ov = 1'b1;
        end else m_ov = 1'b0;
      end
    end else if (rd && q.size() > 0) begin
      m_dout = q.pop_front();
    end
    if (wr_ok) q.push_back(d);
    if (!m_set) begin
      m_set  = 1'b1;
      m_fwft = f;
    end
  endtask

  task automatic step(input bit wr, input logic [DW-1:0] d, input bit rd);
    wr_en = wr; wr_data = d; rd_en = rd;
    model_edge(wr, d, rd);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(input bit s);
    sel = s; rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    q.delete(); m_set = 1'b0; m_ov = 1'b0; m_dout = '0; m_fwft = 1'b0;
    repeat (2) @(negedge clk);
    cur_tag = "R10";
    compare_all();
    rst_n = 1'b1;
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      step(($urandom % 3) != 0, DW'($urandom), ($urandom % 2) == 1);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // ---- FWFT mode ----
    do_reset(1'b0);
    cur_tag = "R1"; step(0, '0, 0);
    cur_tag = "R2"; sel = 1'b1; step(0, '0, 0); step(0, '0, 0);
    cur_tag = "R9"; step(0, '0, 1);
    cur_tag = "R3"; step(1, 16'hA5A5, 0); step(0, '0, 0); step(0, '0, 0);
    cur_tag = "R4"; step(0, '0, 0); step(0, '0, 0);
    cur_tag = "R5";
    for (int i = 0; i < DEPTH; i++) step(1, DW'(16'h100 + i), 0);
    cur_tag = "R9";
    for (int i = 0; i < 3; i++) step(1, DW'(16'hDEAD), 0);
    cur_tag = "R11";
    for (int i = 0; i < DEPTH + 1; i++) step(0, '0, 1);
    cur_tag = "R9"; step(0, '0, 1); step(0, '0, 1);
    cur_tag = "R6";
    step(1, 16'h0042, 0); step(0, '0, 0);
    step(1, 16'h0043, 1); step(0, '0, 0); step(0, '0, 1); step(0, '0, 0);
    cur_tag = "R11"; sel = 1'b0; run_random(300);
    // ---- standard mode ----
    do_reset(1'b1);
    cur_tag = "R1"; step(0, '0, 0);
    cur_tag = "R2"; sel = 1'b0; step(0, '0, 0); step(0, '0, 0);
    cur_tag = "R9"; step(0, '0, 1);
    cur_tag = "R7";
    for (int i = 0; i < DEPTH; i++) step(1, DW'(16'h200 + i), 0);
    cur_tag = "R9"; step(1, 16'hBEEF, 0); step(1, 16'hBEEF, 0);
    cur_tag = "R8";
    for (int i = 0; i < DEPTH; i++) begin
      step(0, '0, 1);
      step(0, '0, 0);
    end
    cur_tag = "R9"; step(0, '0, 1); step(0, '0, 1);
    cur_tag = "R11"; sel = 1'b1; run_random(300);
    // reset mid-run with data present
    cur_tag = "R10"; step(1, 16'h1234, 0);
    do_reset(1'b0);
    cur_tag = "R1"; step(1, 16'h5678, 0); step(0, '0, 0);
    cur_tag = "R11"; run_random(100);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule